// File: doc/BRIEF.md
# Configurable Byte-Wide CRC Generator

This block computes a cyclic redundancy check over a byte stream, taking in one byte on each clock in which the byte strobe is high. The algorithm is set by six values: the register width (8 to 32 bits), the generator polynomial, the starting register value, whether input bytes are taken least-significant bit first, whether the result is bit-reversed, and a mask XORed into the result. A preset parameter selects one of four common configurations: the 32-bit Ethernet frame check, the 16-bit USB data packet check, the 16-bit CCITT check with a zero start value, and the 8-bit ATM cell header check. A custom setting takes all six values from parameters.

A message begins with a start strobe, which loads the starting value. Bytes follow with gaps allowed between them. A finish strobe closes the message. The finished checksum appears on the next clock, together with a one-cycle done pulse, and it holds until the next finish. A byte may come in the same cycle as the start strobe, as the finish strobe, or as both. The eight single-bit division steps for a byte are unrolled into one combinational path. When input bytes are taken LSB first, the register shifts right and uses the bit-reversed polynomial.

Top module: `crc_engine`

## Requirements
- R1: With the Ethernet preset (width 32, polynomial 0x04C11DB7, start 0xFFFFFFFF, both reflections on, output mask 0xFFFFFFFF), the ASCII bytes "123456789" give 0xCBF43926.
- R2: With the USB data preset (width 16, polynomial 0x8005, start 0xFFFF, both reflections on, output mask 0xFFFF), "123456789" gives 0xB4C8.
- R3: With the CCITT preset (width 16, polynomial 0x1021, start 0x0000, no reflection, mask 0x0000), "123456789" gives 0x31C3.
- R4: With the ATM header preset (width 8, polynomial 0x07, start 0x00, no reflection, mask 0x00), "123456789" gives 0xF4.
- R5: For any message and any configuration, absorbing one byte per clock gives exactly the result of MSB-first bit-serial polynomial division, where each byte is bit-reversed first when input reflection is on.
- R6: A start strobe discards any earlier partial message and loads the starting value. When the starting value is reflected, it is loaded in bit-reversed form. A byte that is valid in the same cycle as the start strobe is taken as the first byte of the new message.
- R7: A cycle with the byte strobe low and no start strobe leaves the running remainder unchanged. Idle gaps therefore do not change the result.
- R8: The result and a one-cycle done pulse appear on the clock edge after the finish strobe. A byte valid in the finish cycle is included. Each finish gives exactly one done pulse. The result output holds its value in every cycle that does not follow a finish.
- R9: When output reflection differs from input reflection, the final register is bit-reversed across the full width before the output mask is applied.
- R10: The remainder is held in a 32-bit register whose bits at and above the width stay zero, and the result port is exactly the width. After reset, done is low and the result is zero.
- R11: A message with no bytes gives the starting value passed through the output reflection and the mask. For the Ethernet preset this is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new message by loading the starting value |
| valid_i | input | 1 | data_i carries a message byte this cycle |
| data_i | input | 8 | Message byte |
| finish_i | input | 1 | Close the message and produce the result |
| crc_o | output | WIDTH | Finished checksum, held until the next finish |
| done_o | output | 1 | One-cycle pulse when crc_o is updated |

## Verification
The bound checker enforces on every clock the timing and holding rules. These are: done follows each finish and no other cycle; the result is stable when no finish preceded; the remainder holds through idle cycles; a bare start loads the starting value; and the bits above the width stay clear. Whether the arithmetic is right can only be shown by the bench scenarios. These are the published check values of the four presets on "123456789", and randomly built messages compared against an independent bit-serial model. The bench also covers a 12-bit custom setting whose input and output reflections differ, empty messages, restarts in mid-message, idle gaps, and bytes that arrive together with the start or finish strobe.

// File: rtl/crc_pkg.sv
package crc_pkg;

   typedef enum logic [2:0] {
      CRC_CUSTOM  = 3'd0,
      CRC_ATM8    = 3'd1,
      CRC_USB16   = 3'd2,
      CRC_CCITT16 = 3'd3,
      CRC_ETH32   = 3'd4
   } crc_preset_e;

   typedef struct packed {
      int          width;
      logic [31:0] poly;
      logic [31:0] init;
      logic [31:0] xorout;
      logic        refin;
      logic        refout;
   } crc_cfg_t;

   // all-ones in the low w bits of a 32-bit word
   function automatic logic [31:0] mask_w(input int w);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < w) m[i] = 1'b1;
      end
      return m;
   endfunction

   // mirror the low w bits, clear the rest
   function automatic logic [31:0] reflect_w(input logic [31:0] v, input int w);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < w) r[i] = v[w - 1 - i];
      end
      return r;
   endfunction

   function automatic int pick_width(input crc_preset_e p, input int custom_w);
      case (p)
         CRC_ATM8:    return 8;
         CRC_USB16:   return 16;
         CRC_CCITT16: return 16;
         CRC_ETH32:   return 32;
         default:     return custom_w;
      endcase
   endfunction

   function automatic crc_cfg_t resolve_cfg(
      input crc_preset_e p,
      input int          cw,
      input logic [31:0] cpoly,
      input logic [31:0] cinit,
      input logic        crin,
      input logic        crout,
      input logic [31:0] cxor
   );
      crc_cfg_t c;
      case (p)
         CRC_ATM8:    c = '{width: 8,  poly: 32'h0000_0007, init: 32'h0000_0000,
                            xorout: 32'h0000_0000, refin: 1'b0, refout: 1'b0};
         CRC_USB16:   c = '{width: 16, poly: 32'h0000_8005, init: 32'h0000_FFFF,
                            xorout: 32'h0000_FFFF, refin: 1'b1, refout: 1'b1};
         CRC_CCITT16: c = '{width: 16, poly: 32'h0000_1021, init: 32'h0000_0000,
                            xorout: 32'h0000_0000, refin: 1'b0, refout: 1'b0};
         CRC_ETH32:   c = '{width: 32, poly: 32'h04C1_1DB7, init: 32'hFFFF_FFFF,
                            xorout: 32'hFFFF_FFFF, refin: 1'b1, refout: 1'b1};
         default:     c = '{width: cw, poly: cpoly, init: cinit,
                            xorout: cxor, refin: crin, refout: crout};
      endcase
      c.poly   = c.poly   & mask_w(c.width);
      c.init   = c.init   & mask_w(c.width);
      c.xorout = c.xorout & mask_w(c.width);
      return c;
   endfunction

endpackage

// File: rtl/crc_bit_step.sv
// One division step on the running remainder. The direction comes from a parameter.
module crc_bit_step #(
   parameter int          WIDTH       = 32,
   parameter logic [31:0] POLY_EFF    = 32'h04C1_1DB7,
   parameter bit          SHIFT_RIGHT = 1'b0
) (
   input  logic [31:0] state_i,
   output logic [31:0] state_o
);
   localparam logic [31:0] MASK = crc_pkg::mask_w(WIDTH);
   localparam logic [31:0] POLY = POLY_EFF & MASK;

   generate
      if (SHIFT_RIGHT) begin : g_right
         // LSB-first register: the bit that leaves at the bottom selects the feedback
         logic [31:0] shifted;
         assign shifted = (state_i & MASK) >> 1;
         assign state_o = state_i[0] ? (shifted ^ POLY) : shifted;
      end else begin : g_left
         // MSB-first register: the top bit of the active width selects the feedback
         logic [31:0] shifted;
         logic        top;
         assign top     = state_i[WIDTH-1];
         assign shifted = (state_i << 1) & MASK;
         assign state_o = top ? (shifted ^ POLY) : shifted;
      end
   endgenerate
endmodule

// File: rtl/crc_byte_fold.sv
// Merges one byte into the remainder and applies eight unrolled division steps.
module crc_byte_fold #(
   parameter int          WIDTH       = 32,
   parameter logic [31:0] POLY_EFF    = 32'h04C1_1DB7,
   parameter bit          SHIFT_RIGHT = 1'b0
) (
   input  logic [31:0] state_i,
   input  logic [7:0]  byte_i,
   output logic [31:0] state_o
);
   localparam logic [31:0] MASK    = crc_pkg::mask_w(WIDTH);
   localparam int          NSTEP   = 8;
   localparam int          TOP_OFS = WIDTH - 8;

   logic [NSTEP:0][31:0] chain;

   generate
      if (SHIFT_RIGHT) begin : g_inj_low
         assign chain[0] = (state_i ^ {24'h0, byte_i}) & MASK;
      end else begin : g_inj_high
         assign chain[0] = (state_i ^ ({24'h0, byte_i} << TOP_OFS)) & MASK;
      end

      for (genvar k = 0; k < NSTEP; k++) begin : g_step
         crc_bit_step #(
            .WIDTH      (WIDTH),
            .POLY_EFF   (POLY_EFF),
            .SHIFT_RIGHT(SHIFT_RIGHT)
         ) u_step (
            .state_i(chain[k]),
            .state_o(chain[k+1])
         );
      end
   endgenerate

   assign state_o = chain[NSTEP];
endmodule

// File: rtl/crc_finalize.sv
// Optional full-width mirror, then the output mask.
module crc_finalize #(
   parameter int          WIDTH  = 32,
   parameter bit          MIRROR = 1'b0,
   parameter logic [31:0] XOROUT = 32'h0
) (
   input  logic [WIDTH-1:0] rem_i,
   output logic [WIDTH-1:0] crc_o
);
   logic [WIDTH-1:0] ordered;

   generate
      if (MIRROR) begin : g_mirror
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign ordered[i] = rem_i[WIDTH-1-i];
         end
      end else begin : g_pass
         assign ordered = rem_i;
      end
   endgenerate

   assign crc_o = ordered ^ XOROUT[WIDTH-1:0];
endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
   parameter crc_pkg::crc_preset_e PRESET   = crc_pkg::CRC_ETH32,
   parameter int                   C_WIDTH  = 16,
   parameter logic [31:0]          C_POLY   = 32'h0000_1021,
   parameter logic [31:0]          C_INIT   = 32'h0000_FFFF,
   parameter bit                   C_REFIN  = 1'b0,
   parameter bit                   C_REFOUT = 1'b0,
   parameter logic [31:0]          C_XOROUT = 32'h0000_0000,
   parameter int                   WIDTH    = crc_pkg::pick_width(PRESET, C_WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             valid_i,
   input  logic [7:0]       data_i,
   input  logic             finish_i,
   output logic [WIDTH-1:0] crc_o,
   output logic             done_o
);
   localparam crc_pkg::crc_cfg_t CFG =
      crc_pkg::resolve_cfg(PRESET, C_WIDTH, C_POLY, C_INIT, C_REFIN, C_REFOUT, C_XOROUT);
   localparam bit          RIGHT    = CFG.refin;
   localparam bit          MIRROR   = (CFG.refin != CFG.refout);
   localparam logic [31:0] POLY_EFF = RIGHT ? crc_pkg::reflect_w(CFG.poly, WIDTH) : CFG.poly;
   localparam logic [31:0] INIT_REG = RIGHT ? crc_pkg::reflect_w(CFG.init, WIDTH) : CFG.init;

   generate
      if (WIDTH < 8 || WIDTH > 32) begin : g_bad_width
         $error("crc_engine: WIDTH must lie in 8..32");
      end
      if (WIDTH != CFG.width) begin : g_width_mismatch
         $error("crc_engine: WIDTH override disagrees with the selected preset");
      end
      if (CFG.poly[0] != 1'b1) begin : g_bad_poly
         $error("crc_engine: generator polynomial needs its x^0 term");
      end
   endgenerate

   logic [31:0]      state_q;
   logic [31:0]      base;
   logic [31:0]      folded;
   logic [31:0]      next_state;
   logic [WIDTH-1:0] result;
   logic [WIDTH-1:0] crc_q;
   logic             done_q;

   // a start strobe replaces the running remainder before this cycle's byte
   assign base       = start_i ? INIT_REG : state_q;
   assign next_state = valid_i ? folded : base;

   crc_byte_fold #(
      .WIDTH      (WIDTH),
      .POLY_EFF   (POLY_EFF),
      .SHIFT_RIGHT(RIGHT)
   ) u_fold (
      .state_i(base),
      .byte_i (data_i),
      .state_o(folded)
   );

   crc_finalize #(
      .WIDTH (WIDTH),
      .MIRROR(MIRROR),
      .XOROUT(CFG.xorout)
   ) u_final (
      .rem_i(next_state[WIDTH-1:0]),
      .crc_o(result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= INIT_REG;
         crc_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         if (start_i || valid_i) state_q <= next_state;
         if (finish_i)           crc_q   <= result;
         done_q <= finish_i;
      end
   end

   assign crc_o  = crc_q;
   assign done_o = done_q;
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
   parameter int          WIDTH    = 32,
   parameter logic [31:0] INIT_REG = 32'hFFFF_FFFF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             valid_i,
   input logic             finish_i,
   input logic             done_o,
   input logic [WIDTH-1:0] crc_o,
   input logic [31:0]      state_q
);
   localparam logic [31:0] HIGH_BITS = ~crc_pkg::mask_w(WIDTH);

   // R8: every finish is answered on the next edge
   p_done_after_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
      finish_i |=> done_o);

   // R8: without a finish there is no pulse and the result keeps its value
   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !finish_i |=> (!done_o && $stable(crc_o)));

   // R7: idle cycles leave the remainder alone
   p_idle_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !valid_i) |=> $stable(state_q));

   // R6: a start without a byte leaves exactly the starting value
   p_start_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_i) |=> (state_q == INIT_REG));

   // R10: bits above the active width never become set
   p_upper_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q & HIGH_BITS) == 32'h0));
endmodule

bind crc_engine crc_engine_chk #(
   .WIDTH   (WIDTH),
   .INIT_REG(INIT_REG)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .valid_i (valid_i),
   .finish_i(finish_i),
   .done_o  (done_o),
   .crc_o   (crc_o),
   .state_q (state_q)
);

// File: tb/tb_crc_engine.sv
`timescale 1ns/1ps
module tb_crc_engine;
   import crc_pkg::*;

   localparam int NDUT = 5;  // 0 eth, 1 usb, 2 ccitt, 3 atm, 4 custom

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, valid_i = 1'b0, finish_i = 1'b0;
   logic [7:0] data_i = 8'h0;

   always #2.5 clk = ~clk;

   logic [31:0] crc_eth;
   logic [15:0] crc_usb, crc_cci;
   logic [7:0]  crc_atm;
   logic [11:0] crc_cus;
   logic        d_eth, d_usb, d_cci, d_atm, d_cus;

   crc_engine dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
      .data_i(data_i), .finish_i(finish_i), .crc_o(crc_eth), .done_o(d_eth));
   crc_engine #(.PRESET(CRC_USB16)) dut_usb (.clk(clk), .rst_n(rst_n), .start_i(start_i),
      .valid_i(valid_i), .data_i(data_i), .finish_i(finish_i), .crc_o(crc_usb), .done_o(d_usb));
   crc_engine #(.PRESET(CRC_CCITT16)) dut_cci (.clk(clk), .rst_n(rst_n), .start_i(start_i),
      .valid_i(valid_i), .data_i(data_i), .finish_i(finish_i), .crc_o(crc_cci), .done_o(d_cci));
   crc_engine #(.PRESET(CRC_ATM8)) dut_atm (.clk(clk), .rst_n(rst_n), .start_i(start_i),
      .valid_i(valid_i), .data_i(data_i), .finish_i(finish_i), .crc_o(crc_atm), .done_o(d_atm));
   crc_engine #(.PRESET(CRC_CUSTOM), .C_WIDTH(12), .C_POLY(32'h80F), .C_INIT(32'hABC),
      .C_REFIN(1'b1), .C_REFOUT(1'b0), .C_XOROUT(32'h0F0)) dut_cus (.clk(clk), .rst_n(rst_n),
      .start_i(start_i), .valid_i(valid_i), .data_i(data_i), .finish_i(finish_i),
      .crc_o(crc_cus), .done_o(d_cus));

   logic [31:0] got [NDUT];
   logic        dn  [NDUT];
   assign got[0] = crc_eth;          assign dn[0] = d_eth;
   assign got[1] = {16'h0, crc_usb}; assign dn[1] = d_usb;
   assign got[2] = {16'h0, crc_cci}; assign dn[2] = d_cci;
   assign got[3] = {24'h0, crc_atm}; assign dn[3] = d_atm;
   assign got[4] = {20'h0, crc_cus}; assign dn[4] = d_cus;

   // model configuration, written from the requirements
   int          c_w    [NDUT] = '{32, 16, 16, 8, 12};
   logic [31:0] c_poly [NDUT] = '{32'h04C11DB7, 32'h8005, 32'h1021, 32'h07, 32'h80F};
   logic [31:0] c_init [NDUT] = '{32'hFFFFFFFF, 32'hFFFF, 32'h0, 32'h0, 32'hABC};
   logic        c_rin  [NDUT] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
   logic        c_rout [NDUT] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
   logic [31:0] c_xor  [NDUT] = '{32'hFFFFFFFF, 32'hFFFF, 32'h0, 32'h0, 32'h0F0};
   logic [31:0] pub    [NDUT] = '{32'hCBF43926, 32'hB4C8, 32'h31C3, 32'hF4, 32'h0};
   string       pub_tag[NDUT] = '{"R1", "R2", "R3", "R4", "R5 R9"};

   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t exp_q [NDUT][$];
   logic [31:0] last [NDUT];

   int  checks = 0;
   int  errors = 0;
   bit  mon_en = 1'b0;
   bit  ended  = 1'b0;

   // bit-serial division, MSB first, input bytes mirrored when requested
   function automatic logic [31:0] ref_crc(input int i, input byte unsigned m[$]);
      logic [31:0] mk, r;
      logic [7:0]  b;
      logic        top;
      mk = '0;
      for (int k = 0; k < c_w[i]; k++) mk[k] = 1'b1;
      r = c_init[i] & mk;
      foreach (m[n]) begin
         b = m[n];
         if (c_rin[i]) for (int k = 0; k < 8; k++) b[k] = m[n][7-k];
         for (int j = 7; j >= 0; j--) begin
            top = r[c_w[i]-1] ^ b[j];
            r = (r << 1) & mk;
            if (top) r = r ^ (c_poly[i] & mk);
         end
      end
      if (c_rout[i]) begin
         logic [31:0] t;
         t = '0;
         for (int k = 0; k < c_w[i]; k++) t[k] = r[c_w[i]-1-k];
         r = t;
      end
      return (r ^ c_xor[i]) & mk;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic push_model(input byte unsigned m[$], input string tag);
      for (int i = 0; i < NDUT; i++) begin
         exp_t e;
         e.val = ref_crc(i, m);
         e.tag = (i == 4) ? {tag, " R9 R10"} : tag;
         exp_q[i].push_back(e);
      end
   endtask

   task automatic push_pub(input byte unsigned m[$], input string tag);
      for (int i = 0; i < NDUT; i++) begin
         exp_t e;
         e.val = (i == 4) ? ref_crc(i, m) : pub[i];
         e.tag = {pub_tag[i], " ", tag};
         exp_q[i].push_back(e);
      end
   endtask

   task automatic idle();
      start_i = 1'b0; valid_i = 1'b0; finish_i = 1'b0;
   endtask

   // drive one message; lead = first byte with start, tail = last byte with finish
   task automatic run(input byte unsigned m[$], input bit lead, input bit tail,
                      input int gap, input bit published, input string tag);
      int  n;
      int  first;
      bit  fin;
      n = m.size();
      first = 0;
      fin = 1'b0;
      @(negedge clk);
      idle();
      start_i = 1'b1;
      if (lead && n > 0) begin
         valid_i = 1'b1;
         data_i  = m[0];
         first   = 1;
         if (n == 1 && tail) begin
            finish_i = 1'b1;
            fin = 1'b1;
            if (published) push_pub(m, tag); else push_model(m, tag);
         end
      end
      for (int k = first; k < n; k++) begin
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            idle();
            data_i = 8'hA5;  // noise on the bus while the strobe is low
         end
         @(negedge clk);
         idle();
         valid_i = 1'b1;
         data_i  = m[k];
         if (k == n - 1 && tail) begin
            finish_i = 1'b1;
            fin = 1'b1;
            if (published) push_pub(m, tag); else push_model(m, tag);
         end
      end
      if (!fin) begin
         @(negedge clk);
         idle();
         finish_i = 1'b1;
         if (published) push_pub(m, tag); else push_model(m, tag);
      end
      @(negedge clk);
      idle();
   endtask

   // bytes of an abandoned message: started but never finished
   task automatic abandon(input int len);
      @(negedge clk);
      idle();
      start_i = 1'b1;
      for (int k = 0; k < len; k++) begin
         if (k > 0) begin
            @(negedge clk);
            idle();
         end
         valid_i = 1'b1;
         data_i  = 8'($urandom);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         for (int i = 0; i < NDUT; i++) begin
            if (dn[i]) begin
               if (exp_q[i].size() == 0) begin
                  checks++;
                  errors++;
                  $display("FAIL R8 dut%0d: actual done pulse 0x%08h expected no pulse", i, got[i]);
               end else begin
                  exp_t e;
                  e = exp_q[i].pop_front();
                  check($sformatf("%s dut%0d", e.tag, i), got[i], e.val);
               end
               last[i] = got[i];
            end else begin
               check($sformatf("R8 hold dut%0d", i), got[i], last[i]);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual run still busy expected finished");
      summary();
      $finish;
   end

   initial begin
      byte unsigned s9[$];
      byte unsigned m[$];
      string digits;
      digits = "123456789";
      for (int k = 0; k < 9; k++) s9.push_back(digits[k]);

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      for (int i = 0; i < NDUT; i++) begin
         check($sformatf("R10 reset crc dut%0d", i), got[i], 32'h0);
         check($sformatf("R10 reset done dut%0d", i), {31'h0, dn[i]}, 32'h0);
         last[i] = 32'h0;
      end
      mon_en = 1'b1;

      // R1..R4: published check values, byte on start and finish cycles
      run(s9, 1'b1, 1'b1, 0, 1'b1, "R6 R8");
      // same string, separate start/finish cycles and idle gaps with bus noise
      run(s9, 1'b0, 1'b0, 2, 1'b1, "R7");
      // R11: empty message
      m.delete();
      run(m, 1'b0, 1'b0, 0, 1'b0, "R11");
      // R8: single byte with start and finish together
      m.delete(); m.push_back(8'h31);
      run(m, 1'b1, 1'b1, 0, 1'b0, "R8 single");
      // R6: restart discards an abandoned message
      abandon(5);
      run(s9, 1'b1, 1'b0, 0, 1'b1, "R6 restart");
      abandon(3);
      run(s9, 1'b0, 1'b1, 1, 1'b1, "R6 restart bare");
      // R5: random messages against the bit-serial model
      for (int t = 0; t < 40; t++) begin
         int len;
         len = 1 + int'($urandom_range(0, 19));
         m.delete();
         for (int k = 0; k < len; k++) m.push_back(8'($urandom));
         run(m, 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)), 1'b0, "R5");
      end

      repeat (4) @(negedge clk);
      // R8: every finish answered by exactly one pulse
      for (int i = 0; i < NDUT; i++)
         check($sformatf("R8 pending results dut%0d", i), exp_q[i].size(), 32'h0);
      summary();
      $finish;
   end
endmodule